// File: doc/BRIEF.md
# Exception Nesting and Escalation Controller

This block keeps track of how deep the processor sits in fault handling and decides what each new exception turns into. Exceptions reach it from three places: a vector of hardware request lines, each line with its own error code; two conditions it detects itself, a divide with a zero divisor and a taken branch to a misaligned target; and a software interrupt request that carries a cause number. When several exceptions arrive in the same cycle, one winner is chosen by cause number. A handler-return pulse tells the block that the current handler has finished.

With no handler active, an accepted exception dispatches its own vector and the block records the cause and the error code. A second exception raised before the handler returns escalates into a double fault, which has a vector of its own. A third exception raised during the double fault cannot be recovered from: the block sends a one-cycle processor-reset request and drops back to the base level. All outputs are registered and appear one clock after the inputs that cause them.

Top module: `exc_escalator`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises with idle inputs, `nest_lvl` is 0 (no handler active) and `vec_valid`, `vec_sel`, `cause_q`, `err_q`, `double_fault`, `reset_req` and `resume` are all 0.
- R2: An exception accepted at level 0 drives `vec_valid` high for exactly the next cycle with `vec_sel` equal to the winning cause, moves `nest_lvl` to 1 (handler active) and loads `cause_q`/`err_q` with the winner's cause and error code.
- R3: When several causes are raised in the same cycle, the lowest cause number wins and the others are dropped.
- R4: Error codes: a hardware line reports its own `hw_err` slice (line c in bits c*ERR_W upward); divide-by-zero reports 0; misalignment reports the target's two low address bits, zero-extended; a software interrupt reports 0. On a cause raised both internally and by its hardware line, the internal code wins.
- R5: An exception accepted at level 1 with no handler return in the same cycle moves `nest_lvl` to 2 (double fault), raises `double_fault`, pulses `vec_valid` with `vec_sel` equal to NUM_CAUSES, and loads the new cause and error code.
- R6: An exception at level 2 with no handler return in the same cycle pulses `reset_req` for one cycle, returns `nest_lvl` to 0, gives no `vec_valid`, and leaves `cause_q`/`err_q` unchanged.
- R7: A handler return at level 1 or 2 pulses `resume` for one cycle and returns `nest_lvl` to 0; a handler return at level 0 has no effect on any output.
- R8: A handler return and an exception in the same cycle are taken in that order: the return lowers the level to 0 and the exception is then accepted as in R2, so `resume` and `vec_valid` both pulse.
- R9: `div_valid` with `div_divisor` equal to 0 raises cause 0; `div_valid` with a non-zero divisor raises nothing.
- R10: A taken branch (`br_taken`) whose `br_target` has non-zero bits [1:0] raises cause 1; a taken branch to an aligned target, or a branch that is not taken, raises nothing.
- R11: `swi_valid` raises cause `swi_num` and is ordered and escalated exactly as a hardware request of that cause.
- R12: `cause_q` and `err_q` change only in a cycle where `vec_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_req | input | NUM_CAUSES | Hardware exception request, one line per cause |
| hw_err | input | NUM_CAUSES*ERR_W | Error code for each hardware line |
| div_valid | input | 1 | A divide is executing this cycle |
| div_divisor | input | DATA_W | Divisor of that divide |
| br_taken | input | 1 | A branch or jump is taken this cycle |
| br_target | input | ADDR_W | Target address of the taken branch |
| swi_valid | input | 1 | Software interrupt request |
| swi_num | input | CAUSE_W | Cause number of the software interrupt |
| hret | input | 1 | Handler return pulse |
| vec_valid | output | 1 | Dispatch the handler named by vec_sel |
| vec_sel | output | CAUSE_W+1 | Vector to dispatch; NUM_CAUSES selects the double-fault handler |
| cause_q | output | CAUSE_W | Cause of the last accepted exception |
| err_q | output | ERR_W | Error code of the last accepted exception |
| double_fault | output | 1 | High while the double-fault handler is active |
| reset_req | output | 1 | One-cycle processor reset request |
| resume | output | 1 | One-cycle pulse: the interrupted task resumes |
| nest_lvl | output | 2 | Nesting level: 0 none, 1 handler, 2 double fault |

## Verification
Two functions can land in the same cycle: a handler return and a new exception. The bench provokes this at level 1 with a software interrupt, and at level 2 with a hardware request. It expects `resume` and a first-level vector together, and no escalation. The lowest-number rule is also exercised in the same way, by raising two hardware lines together, a divide-by-zero with a misaligned branch, and an internal cause on top of its own hardware line. In each case the bench compares the dispatched cause and the error code against a model it keeps of the rules.

// File: rtl/exc_esc_pkg.sv
// Shared definitions for the exception escalation controller.
// Assumes nothing beyond a 2-bit nesting level encoding.
package exc_esc_pkg;

    // Nesting level; the numeric codes are visible on nest_lvl.
    typedef enum logic [1:0] {
        LVL_NORMAL  = 2'd0,
        LVL_HANDLER = 2'd1,
        LVL_DOUBLE  = 2'd2
    } nest_lvl_e;

endpackage

// File: rtl/exc_detect.sv
// Exception source merger.
// Turns the divide-by-zero and misaligned-taken-branch conditions and the
// software interrupt into cause bits, ORs them with the hardware request
// lines, and picks an error code per cause. Internal sources own causes 0
// (divide) and 1 (alignment); their code overrides the hardware line's.
// Assumes NUM_CAUSES >= 2 and ERR_W >= 2.
module exc_detect #(
    parameter int NUM_CAUSES = 16,
    parameter int ERR_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    localparam int CAUSE_W   = $clog2(NUM_CAUSES)
) (
    input  logic [NUM_CAUSES-1:0]       hw_req,
    input  logic [NUM_CAUSES*ERR_W-1:0] hw_err,
    input  logic                        div_valid,
    input  logic [DATA_W-1:0]           div_divisor,
    input  logic                        br_taken,
    input  logic [ADDR_W-1:0]           br_target,
    input  logic                        swi_valid,
    input  logic [CAUSE_W-1:0]          swi_num,
    output logic [NUM_CAUSES-1:0]       pend,
    output logic [NUM_CAUSES*ERR_W-1:0] pend_err
);

    localparam int DIV_CAUSE   = 0;
    localparam int ALIGN_CAUSE = 1;

    logic                        div_zero;
    logic                        misalign;
    logic [NUM_CAUSES-1:0]       int_hit;
    logic [NUM_CAUSES*ERR_W-1:0] int_err;
    logic [NUM_CAUSES-1:0]       swi_hit;

    // Detect the two internally generated fault conditions.
    always_comb begin
        div_zero = div_valid && (div_divisor == '0);
        misalign = br_taken && (br_target[1:0] != 2'b00);
    end

    // Place internal faults on their fixed cause bits with their codes.
    always_comb begin
        int_hit = '0;
        int_err = '0;
        int_hit[DIV_CAUSE]   = div_zero;
        int_hit[ALIGN_CAUSE] = misalign;
        int_err[ALIGN_CAUSE*ERR_W +: ERR_W] = ERR_W'(br_target[1:0]);
    end

    // Decode the software interrupt number into a one-hot cause bit.
    always_comb begin
        swi_hit = '0;
        for (int i = 0; i < NUM_CAUSES; i++) begin
            if (swi_valid && (swi_num == CAUSE_W'(i))) begin
                swi_hit[i] = 1'b1;
            end
        end
    end

    // Per cause: merge the three sources and select the error code.
    for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_cause
        always_comb begin
            pend[g] = hw_req[g] | int_hit[g] | swi_hit[g];
            if (int_hit[g]) begin
                pend_err[g*ERR_W +: ERR_W] = int_err[g*ERR_W +: ERR_W];
            end else if (hw_req[g]) begin
                pend_err[g*ERR_W +: ERR_W] = hw_err[g*ERR_W +: ERR_W];
            end else begin
                pend_err[g*ERR_W +: ERR_W] = '0;
            end
        end
    end

endmodule

// File: rtl/exc_prio.sv
// Fixed-priority picker: the lowest pending cause number wins; every other
// pending cause in that cycle is dropped. Purely combinational.
module exc_prio #(
    parameter int NUM_CAUSES = 16,
    parameter int ERR_W      = 16,
    localparam int CAUSE_W   = $clog2(NUM_CAUSES)
) (
    input  logic [NUM_CAUSES-1:0]       pend,
    input  logic [NUM_CAUSES*ERR_W-1:0] pend_err,
    output logic                        any,
    output logic [CAUSE_W-1:0]          win_cause,
    output logic [ERR_W-1:0]            win_err
);

    // Scan from the top down so the lowest set index is written last.
    always_comb begin
        any       = |pend;
        win_cause = '0;
        win_err   = '0;
        for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win_cause = CAUSE_W'(i);
                win_err   = pend_err[i*ERR_W +: ERR_W];
            end
        end
    end

endmodule

// File: rtl/exc_nest_fsm.sv
// Nesting-level state machine and registered outputs.
// A handler return is applied first, then any exception is judged at the
// resulting level: first level vectors the cause, second level vectors
// the double-fault handler, third level asks for a processor reset.
// Assumes exc_any/exc_cause/exc_err are stable around the clock edge.
module exc_nest_fsm
    import exc_esc_pkg::*;
#(
    parameter int NUM_CAUSES = 16,
    parameter int ERR_W      = 16,
    localparam int CAUSE_W   = $clog2(NUM_CAUSES),
    localparam int VEC_W     = CAUSE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_any,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic [ERR_W-1:0]   exc_err,
    input  logic               hret,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_sel,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [ERR_W-1:0]   err_q,
    output logic               double_fault,
    output logic               reset_req,
    output logic               resume,
    output logic [1:0]         nest_lvl
);

    localparam logic [VEC_W-1:0] DF_VEC = VEC_W'(NUM_CAUSES);

    nest_lvl_e          lvl_q, lvl_d, lvl_eff;
    logic               vv_d, rr_d, rs_d, latch_d;
    logic [VEC_W-1:0]   vs_d;

    // Decide the next level and the pulses for this cycle.
    always_comb begin
        rs_d    = 1'b0;
        vv_d    = 1'b0;
        rr_d    = 1'b0;
        latch_d = 1'b0;
        vs_d    = '0;
        lvl_eff = lvl_q;
        if (hret && (lvl_q != LVL_NORMAL)) begin
            rs_d    = 1'b1;
            lvl_eff = LVL_NORMAL;
        end
        lvl_d = lvl_eff;
        if (exc_any) begin
            unique case (lvl_eff)
                LVL_NORMAL: begin
                    vv_d    = 1'b1;
                    vs_d    = VEC_W'(exc_cause);
                    latch_d = 1'b1;
                    lvl_d   = LVL_HANDLER;
                end
                LVL_HANDLER: begin
                    vv_d    = 1'b1;
                    vs_d    = DF_VEC;
                    latch_d = 1'b1;
                    lvl_d   = LVL_DOUBLE;
                end
                default: begin
                    rr_d  = 1'b1;
                    lvl_d = LVL_NORMAL;
                end
            endcase
        end
    end

    // Register the level and the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q     <= LVL_NORMAL;
            vec_valid <= 1'b0;
            vec_sel   <= '0;
            reset_req <= 1'b0;
            resume    <= 1'b0;
        end else begin
            lvl_q     <= lvl_d;
            vec_valid <= vv_d;
            vec_sel   <= vs_d;
            reset_req <= rr_d;
            resume    <= rs_d;
        end
    end

    // Hold cause and error code until the next dispatched vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            err_q   <= '0;
        end else if (latch_d) begin
            cause_q <= exc_cause;
            err_q   <= exc_err;
        end
    end

    // Expose the level and its double-fault view.
    always_comb begin
        nest_lvl     = lvl_q;
        double_fault = (lvl_q == LVL_DOUBLE);
    end

endmodule

// File: rtl/exc_escalator.sv
// Exception escalation controller, top level.
// Merges hardware, divide, alignment and software exception sources, picks
// the lowest cause, and tracks nesting to escalate into a double fault and
// then into a processor reset request. Outputs are one cycle after inputs.
module exc_escalator #(
    parameter int NUM_CAUSES = 16,
    parameter int ERR_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    localparam int CAUSE_W   = $clog2(NUM_CAUSES),
    localparam int VEC_W     = CAUSE_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CAUSES-1:0]       hw_req,
    input  logic [NUM_CAUSES*ERR_W-1:0] hw_err,
    input  logic                        div_valid,
    input  logic [DATA_W-1:0]           div_divisor,
    input  logic                        br_taken,
    input  logic [ADDR_W-1:0]           br_target,
    input  logic                        swi_valid,
    input  logic [CAUSE_W-1:0]          swi_num,
    input  logic                        hret,
    output logic                        vec_valid,
    output logic [VEC_W-1:0]            vec_sel,
    output logic [CAUSE_W-1:0]          cause_q,
    output logic [ERR_W-1:0]            err_q,
    output logic                        double_fault,
    output logic                        reset_req,
    output logic                        resume,
    output logic [1:0]                  nest_lvl
);

    logic [NUM_CAUSES-1:0]       pend;
    logic [NUM_CAUSES*ERR_W-1:0] pend_err;
    logic                        exc_any;
    logic [CAUSE_W-1:0]          exc_cause;
    logic [ERR_W-1:0]            exc_err;

    exc_detect #(
        .NUM_CAUSES (NUM_CAUSES),
        .ERR_W      (ERR_W),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W)
    ) u_detect (
        .hw_req      (hw_req),
        .hw_err      (hw_err),
        .div_valid   (div_valid),
        .div_divisor (div_divisor),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .swi_valid   (swi_valid),
        .swi_num     (swi_num),
        .pend        (pend),
        .pend_err    (pend_err)
    );

    exc_prio #(
        .NUM_CAUSES (NUM_CAUSES),
        .ERR_W      (ERR_W)
    ) u_prio (
        .pend      (pend),
        .pend_err  (pend_err),
        .any       (exc_any),
        .win_cause (exc_cause),
        .win_err   (exc_err)
    );

    exc_nest_fsm #(
        .NUM_CAUSES (NUM_CAUSES),
        .ERR_W      (ERR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_any      (exc_any),
        .exc_cause    (exc_cause),
        .exc_err      (exc_err),
        .hret         (hret),
        .vec_valid    (vec_valid),
        .vec_sel      (vec_sel),
        .cause_q      (cause_q),
        .err_q        (err_q),
        .double_fault (double_fault),
        .reset_req    (reset_req),
        .resume       (resume),
        .nest_lvl     (nest_lvl)
    );

endmodule

// File: rtl/exc_escalator_chk.sv
// Property checker for exc_escalator, attached through bind below.
// Observes ports only.
module exc_escalator_chk #(
    parameter int NUM_CAUSES = 16,
    parameter int ERR_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    localparam int CAUSE_W   = $clog2(NUM_CAUSES),
    localparam int VEC_W     = CAUSE_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               div_valid,
    input logic [DATA_W-1:0]  div_divisor,
    input logic               br_taken,
    input logic [ADDR_W-1:0]  br_target,
    input logic               vec_valid,
    input logic [VEC_W-1:0]   vec_sel,
    input logic [CAUSE_W-1:0] cause_q,
    input logic [ERR_W-1:0]   err_q,
    input logic               double_fault,
    input logic               reset_req,
    input logic               resume,
    input logic [1:0]         nest_lvl
);

    localparam logic [VEC_W-1:0] DF_VEC = VEC_W'(NUM_CAUSES);

    assert_df_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_sel == DF_VEC) |-> (double_fault && nest_lvl == 2'd2));

    assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    assert_reset_from_double_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> ($past(nest_lvl) == 2'd2 && nest_lvl == 2'd0));

    assert_reset_no_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vec_valid, reset_req}));

    assert_resume_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> ($past(nest_lvl) != 2'd0 && nest_lvl != 2'd2));

    assert_div_zero_raises_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (div_valid && div_divisor == '0) |=> (vec_valid || reset_req));

    assert_misalign_raises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && br_target[1:0] != 2'b00) |=> (vec_valid || reset_req));

    assert_latch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> ($stable(cause_q) && $stable(err_q)));

endmodule

bind exc_escalator exc_escalator_chk #(
    .NUM_CAUSES (NUM_CAUSES),
    .ERR_W      (ERR_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
) u_chk (.*);

// File: tb/exc_escalator_test.sv
// Scoreboard bench: the driver computes each cycle's expected outputs from
// the requirements and queues them; a monitor compares at the falling edge.
module exc_escalator_test;

    localparam int CLK_PERIOD = 10;
    localparam int NC  = 16;
    localparam int EW  = 16;
    localparam int CW  = 4;
    localparam int VW  = 5;

    typedef struct {
        string          tag;
        logic           vv;
        logic [VW-1:0]  vs;
        logic [CW-1:0]  c;
        logic [EW-1:0]  e;
        logic           df;
        logic           rr;
        logic           rs;
        logic [1:0]     lv;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     hw_req = '0;
    logic [NC*EW-1:0]  hw_err = '0;
    logic              div_valid = 1'b0;
    logic [31:0]       div_divisor = '0;
    logic              br_taken = 1'b0;
    logic [31:0]       br_target = '0;
    logic              swi_valid = 1'b0;
    logic [CW-1:0]     swi_num = '0;
    logic              hret = 1'b0;
    logic              vec_valid;
    logic [VW-1:0]     vec_sel;
    logic [CW-1:0]     cause_q;
    logic [EW-1:0]     err_q;
    logic              double_fault, reset_req, resume;
    logic [1:0]        nest_lvl;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb[$];

    logic [1:0]    m_lvl = 2'd0;
    logic [CW-1:0] m_cause = '0;
    logic [EW-1:0] m_err = '0;

    exc_escalator uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Build the expected outputs for the inputs currently driven.
    function automatic exp_t model(string tag);
        exp_t x;
        logic [NC-1:0] p;
        logic [EW-1:0] pe [NC];
        logic any;
        logic [CW-1:0] w;
        logic [1:0] eff;
        x.tag = tag; x.vv = 0; x.vs = '0; x.rr = 0; x.rs = 0;
        for (int c = 0; c < NC; c++) begin
            p[c]  = hw_req[c] | (swi_valid && swi_num == CW'(c));
            pe[c] = hw_req[c] ? hw_err[c*EW +: EW] : '0;
        end
        if (br_taken && br_target[1:0] != 0) begin p[1] = 1; pe[1] = EW'(br_target[1:0]); end
        if (div_valid && div_divisor == 0) begin p[0] = 1; pe[0] = '0; end
        any = |p; w = '0;
        for (int c = NC - 1; c >= 0; c--) if (p[c]) w = CW'(c);
        eff = m_lvl;
        if (hret && m_lvl != 0) begin x.rs = 1; eff = 0; end
        m_lvl = eff;
        if (any) begin
            case (eff)
                2'd0: begin x.vv = 1; x.vs = VW'(w); m_lvl = 1; m_cause = w; m_err = pe[w]; end
                2'd1: begin x.vv = 1; x.vs = VW'(NC); m_lvl = 2; m_cause = w; m_err = pe[w]; end
                default: begin x.rr = 1; m_lvl = 0; end
            endcase
        end
        x.c = m_cause; x.e = m_err; x.df = (m_lvl == 2); x.lv = m_lvl;
        return x;
    endfunction

    // Driver: model this cycle, let the edge pass, queue result, go idle.
    task automatic step(string tag);
        exp_t x;
        x = model(tag);
        @(posedge clk);
        #1;
        sb.push_back(x);
        hw_req = '0; hw_err = '0; div_valid = 0; div_divisor = '0;
        br_taken = 0; br_target = '0; swi_valid = 0; swi_num = '0; hret = 0;
    endtask

    // Monitor: compare the queued expectation at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            checks++;
            if ({vec_valid, vec_sel, cause_q, err_q, double_fault, reset_req, resume, nest_lvl} !==
                {x.vv, x.vs, x.c, x.e, x.df, x.rr, x.rs, x.lv}) begin
                errors++;
                $display("FAIL %s got vv=%b vs=%0d c=%0d e=%h df=%b rr=%b rs=%b lv=%0d exp vv=%b vs=%0d c=%0d e=%h df=%b rr=%b rs=%b lv=%0d",
                    x.tag, vec_valid, vec_sel, cause_q, err_q, double_fault, reset_req, resume, nest_lvl,
                    x.vv, x.vs, x.c, x.e, x.df, x.rr, x.rs, x.lv);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({vec_valid, vec_sel, cause_q, err_q, double_fault, reset_req, resume, nest_lvl} !== '0) begin
            errors++;
            $display("FAIL R1 in reset got %b exp 0",
                {vec_valid, vec_sel, cause_q, err_q, double_fault, reset_req, resume, nest_lvl});
        end
        @(posedge clk); #1; rst_n = 1;
        step("R1 idle after reset");
        hw_req[5] = 1; hw_err[5*EW +: EW] = 16'h1234;
        step("R2 first-level hw cause 5");
        step("R12 latch held while idle");
        hret = 1;
        step("R7 return from handler");
        hret = 1;
        step("R7 return at level 0 ignored");
        hw_req[3] = 1; hw_req[7] = 1; hw_err[3*EW +: EW] = 16'h0033; hw_err[7*EW +: EW] = 16'h0077;
        step("R3 lowest of causes 3 and 7");
        hw_req[9] = 1; hw_err[9*EW +: EW] = 16'h0999;
        step("R5 nested exception escalates");
        br_taken = 0; br_target = 32'h0000_1002;
        step("R10 not-taken misaligned branch ignored");
        br_taken = 1; br_target = 32'h0000_1004;
        step("R10 taken aligned branch ignored");
        div_valid = 1; div_divisor = 32'd7;
        step("R9 nonzero divisor ignored");
        div_valid = 1; div_divisor = 32'd0;
        step("R6 divide-by-zero in double fault resets");
        step("R6 reset pulse drops");
        br_taken = 1; br_target = 32'h0000_2002;
        step("R10 taken misaligned branch cause 1");
        hret = 1; swi_valid = 1; swi_num = 4'd4;
        step("R8 return with software interrupt");
        div_valid = 1; div_divisor = 32'd0; hw_req[0] = 1; hw_err[0] = 1'b1; hw_err[15:0] = 16'hBEEF;
        step("R4 internal code beats hw line 0, escalates");
        hret = 1; hw_req[6] = 1; hw_err[6*EW +: EW] = 16'h0066;
        step("R8 return from double fault with hw cause 6");
        hret = 1;
        step("R7 return lowers to level 0");
        div_valid = 1; div_divisor = 32'd0; br_taken = 1; br_target = 32'h0000_0003;
        step("R3 divide beats misalignment");
        swi_valid = 1; swi_num = 4'd11;
        step("R11 software interrupt escalates");
        hw_req[2] = 1; hw_err[2*EW +: EW] = 16'h0222;
        step("R6 reset keeps latched cause");
        hret = 1;
        step("R7 return at level 0 after reset ignored");
        swi_valid = 1; swi_num = 4'd13;
        step("R11 software interrupt first level");
        @(negedge clk); @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule